// File: doc/BRIEF.md
# Multi-Mode Branch Direction Predictor

This block tells an instruction fetch stage whether a conditional branch is likely to be taken. The fetch stage presents a branch address and a one-bit kind tag (ordinary conditional or loop-closing). The block answers with a taken/not-taken guess combinationally, in the same cycle. When the branch later resolves, the execute side sends back the address, the real outcome, and the guess that was used. The block then trains its history tables and counts mispredictions.

A two-bit strategy input chooses how the guess is formed, and it can be changed at run time. The fixed strategy always guesses not taken. The kind-based strategy guesses from the tag alone. Two history-based strategies read a small direct-mapped table selected by low address bits. One takes a majority vote over the last three outcomes seen at that slot. The other uses a saturating two-bit confidence state. Both history tables are trained on every resolved branch, whichever strategy is active, so a switch of strategy starts from warm history.

Top module: `bdp_predictor`

## Requirements
- R1: After reset, all vote histories are 000 and all confidence states are 01, so every slot guesses not taken in strategies 2'b10 and 2'b11, and both counters read zero.
- R2: With strategy 2'b00 (fixed), pred_taken is 0 for every query, whatever the history or the kind tag.
- R3: With strategy 2'b01 (kind-based), a query with q_loop=0 (ordinary conditional) guesses not taken and a query with q_loop=1 (loop-closing) guesses taken.
- R4: With strategy 2'b10 (vote), the guess is taken when at least two of the three most recent outcomes trained into the slot were taken. Each update shifts the new outcome in at bit 0 and drops the oldest bit (bit 2).
- R5: With strategy 2'b11 (confidence), states 00 and 01 guess not taken and 10 and 11 guess taken. A taken outcome steps the state up by one and a not-taken outcome steps it down by one, saturating at 11 and at 00.
- R6: The slot is chosen by address bits [5:2] for both query and update. All other address bits are ignored, so addresses that differ only in those other bits share a slot.
- R7: When a query and an update name the same slot in the same cycle, the guess comes from the contents held before that update.
- R8: Every cycle with u_valid=1 trains both history tables, whatever strategy is selected.
- R9: stat_total counts the cycles with q_valid=1. stat_miss counts the cycles with u_valid=1 and u_guess different from u_taken.
- R10: pred_taken is 0 in any cycle with q_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Strategy: 00 fixed, 01 kind-based, 10 vote, 11 confidence |
| q_valid | input | 1 | Query present this cycle |
| q_addr | input | ADDR_W | Address of the queried branch |
| q_loop | input | 1 | Kind tag: 1 loop-closing, 0 ordinary conditional |
| pred_taken | output | 1 | Guess for the query, same cycle |
| u_valid | input | 1 | Resolved-branch update present |
| u_addr | input | ADDR_W | Address of the resolved branch |
| u_taken | input | 1 | Actual outcome |
| u_guess | input | 1 | Guess that was used for this branch |
| stat_total | output | CNT_W | Count of queries |
| stat_miss | output | CNT_W | Count of resolved branches that were guessed wrong |

## Verification
The assertions assume that reset is held across at least one clock edge before use and that the strategy input is a defined two-bit value in every cycle. They also assume that the counters stay below their wrap point during a run. The stimulus keeps within these limits: reset is held for three edges, the strategy is always drawn from the four legal codes, and the whole run makes far fewer queries and updates than the counters can hold. Random updates often reuse the query address, so same-slot collisions within one cycle occur many times without being set up by hand.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef enum logic [1:0] {
    MODE_NEVER  = 2'b00,
    MODE_BYKIND = 2'b01,
    MODE_VOTE   = 2'b10,
    MODE_CONF   = 2'b11
  } bdp_mode_e;

  localparam logic [1:0] CONF_INIT = 2'b01;

  // one saturating step of a two-bit confidence state
  function automatic logic [1:0] conf_next(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    nxt = cur;
    if (taken) begin
      if (cur != 2'b11) nxt = cur + 2'd1;
    end else begin
      if (cur != 2'b00) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bdp_vote_table.sv
module bdp_vote_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int CNT_BITS = $clog2(HIST_W + 1);

  logic [HIST_W-1:0] hist_q [SLOTS];
  logic [HIST_W-1:0] rd_word;
  logic [CNT_BITS-1:0] ones;

  // one register per slot, each with its own write enable
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        hist_q[s] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(s))) begin
        hist_q[s] <= {hist_q[s][HIST_W-2:0], wr_taken};
      end
    end
  end

  assign rd_word = hist_q[rd_idx];

  always_comb begin
    ones = '0;
    for (int b = 0; b < HIST_W; b++) begin
      ones = ones + CNT_BITS'(rd_word[b]);
    end
  end

  // strict majority of the recorded outcomes
  assign rd_taken = (32'(ones) * 2) > HIST_W;

endmodule

// File: rtl/bdp_conf_table.sv
module bdp_conf_table
  import bdp_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int SLOTS = 1 << IDX_W;

  logic [1:0] conf_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        conf_q[s] <= CONF_INIT;
      end else if (wr_en && (wr_idx == IDX_W'(s))) begin
        conf_q[s] <= conf_next(conf_q[s], wr_taken);
      end
    end
  end

  // upper bit of the state carries the direction
  assign rd_taken = conf_q[rd_idx][1];

endmodule

// File: rtl/bdp_stats.sv
module bdp_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_fire,
  input  logic             miss_fire,
  output logic [CNT_W-1:0] total_q,
  output logic [CNT_W-1:0] miss_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      miss_q  <= '0;
    end else begin
      if (q_fire)    total_q <= total_q + CNT_W'(1);
      if (miss_fire) miss_q  <= miss_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bdp_predictor.sv
module bdp_predictor
  import bdp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 4,
  parameter int HIST_W  = 3,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              q_valid,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              q_loop,
  output logic              pred_taken,
  input  logic              u_valid,
  input  logic [ADDR_W-1:0] u_addr,
  input  logic              u_taken,
  input  logic              u_guess,
  output logic [CNT_W-1:0]  stat_total,
  output logic [CNT_W-1:0]  stat_miss
);
  localparam int IDX_HI = IDX_LSB + IDX_W;

  logic [IDX_W-1:0] q_idx, u_idx;
  logic vote_taken, conf_taken;
  logic guess;
  bdp_mode_e mode_e;
  logic unused_addr_bits;

  assign q_idx = q_addr[IDX_HI-1:IDX_LSB];
  assign u_idx = u_addr[IDX_HI-1:IDX_LSB];
  assign unused_addr_bits = ^{q_addr[ADDR_W-1:IDX_HI], q_addr[IDX_LSB-1:0],
                              u_addr[ADDR_W-1:IDX_HI], u_addr[IDX_LSB-1:0]};

  bdp_vote_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_vote (
    .clk(clk), .rst(rst),
    .rd_idx(q_idx), .rd_taken(vote_taken),
    .wr_en(u_valid), .wr_idx(u_idx), .wr_taken(u_taken)
  );

  bdp_conf_table #(.IDX_W(IDX_W)) u_conf (
    .clk(clk), .rst(rst),
    .rd_idx(q_idx), .rd_taken(conf_taken),
    .wr_en(u_valid), .wr_idx(u_idx), .wr_taken(u_taken)
  );

  bdp_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst),
    .q_fire(q_valid),
    .miss_fire(u_valid && (u_guess != u_taken)),
    .total_q(stat_total), .miss_q(stat_miss)
  );

  assign mode_e = bdp_mode_e'(mode);

  always_comb begin
    unique case (mode_e)
      MODE_NEVER:  guess = 1'b0;
      MODE_BYKIND: guess = q_loop;
      MODE_VOTE:   guess = vote_taken;
      MODE_CONF:   guess = conf_taken;
      default:     guess = 1'b0;
    endcase
  end

  assign pred_taken = q_valid && guess;

endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             q_valid,
  input logic             q_loop,
  input logic             pred_taken,
  input logic             u_valid,
  input logic             u_taken,
  input logic             u_guess,
  input logic [CNT_W-1:0] stat_total,
  input logic [CNT_W-1:0] stat_miss
);
  // R2: fixed strategy never guesses taken
  a_r2_fixed_never: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |-> !pred_taken);

  // R3: kind-based strategy follows the tag
  a_r3_kind_follow: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && q_valid) |-> (pred_taken == q_loop));

  // R10: no guess without a query
  a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
    !q_valid |-> !pred_taken);

  // R9: query counter advances by one per query
  a_r9_total_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_total == $past(stat_total) + CNT_W'($past(q_valid))));

  // R9: miss counter advances only on a wrong resolved guess
  a_r9_miss_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_miss == $past(stat_miss)
                + CNT_W'($past(u_valid && (u_guess != u_taken)))));
endmodule

bind bdp_predictor bdp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .q_valid(q_valid), .q_loop(q_loop),
  .pred_taken(pred_taken), .u_valid(u_valid), .u_taken(u_taken),
  .u_guess(u_guess), .stat_total(stat_total), .stat_miss(stat_miss)
);

// File: tb/sim_bdp_predictor.sv
module sim_bdp_predictor;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, q_valid, q_loop, u_valid, u_taken, u_guess, pred_taken;
  logic [1:0] mode;
  logic [ADDR_W-1:0] q_addr, u_addr;
  logic [CNT_W-1:0] stat_total, stat_miss;

  bdp_predictor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .q_valid(q_valid), .q_addr(q_addr),
    .q_loop(q_loop), .pred_taken(pred_taken), .u_valid(u_valid),
    .u_addr(u_addr), .u_taken(u_taken), .u_guess(u_guess),
    .stat_total(stat_total), .stat_miss(stat_miss)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [2:0] m_hist [16];
  logic [1:0] m_conf [16];
  int m_tot = 0;
  int m_miss = 0;

  function automatic logic exp_pred(input logic [1:0] md, input logic qv,
                                    input logic [31:0] a, input logic lp);
    logic [3:0] i;
    int ones;
    i = a[5:2];
    ones = int'(m_hist[i][0]) + int'(m_hist[i][1]) + int'(m_hist[i][2]);
    if (!qv) return 1'b0;
    case (md)
      2'b00:   return 1'b0;
      2'b01:   return lp;
      2'b10:   return ones >= 2;
      default: return m_conf[i][1];
    endcase
  endfunction

  function automatic logic [1:0] conf_step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  task automatic step(input logic [1:0] md, input logic qv, input logic [31:0] qa,
                      input logic ql, input logic uv, input logic [31:0] ua,
                      input logic ut, input logic ug, input string tag);
    logic e;
    mode = md; q_valid = qv; q_addr = qa; q_loop = ql;
    u_valid = uv; u_addr = ua; u_taken = ut; u_guess = ug;
    #2;
    e = exp_pred(md, qv, qa, ql);
    total++;
    if (pred_taken !== e) begin
      bad++;
      $display("FAIL %s mode=%b addr=%h pred=%b expected=%b", tag, md, qa, pred_taken, e);
    end
    @(posedge clk);
    if (qv) m_tot++;
    if (uv) begin
      m_hist[ua[5:2]] = {m_hist[ua[5:2]][1:0], ut};
      m_conf[ua[5:2]] = conf_step(m_conf[ua[5:2]], ut);
      if (ug != ut) m_miss++;
    end
    @(negedge clk);
  endtask

  task automatic train(input logic [1:0] md, input logic [31:0] a, input logic t);
    step(md, 1'b0, 32'h0, 1'b0, 1'b1, a, t, 1'b0, "R10 idle during training");
  endtask

  task automatic ask(input logic [1:0] md, input logic [31:0] a, input logic lp,
                     input string tag);
    step(md, 1'b1, a, lp, 1'b0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic chk_cnt(input string tag);
    total++;
    if (stat_total !== CNT_W'(m_tot) || stat_miss !== CNT_W'(m_miss)) begin
      bad++;
      $display("FAIL %s total=%0d miss=%0d expected total=%0d miss=%0d",
               tag, stat_total, stat_miss, m_tot, m_miss);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin
      m_hist[i] = 3'b000;
      m_conf[i] = 2'b01;
    end
    rst = 1'b1; mode = 2'b00; q_valid = 0; q_addr = '0; q_loop = 0;
    u_valid = 0; u_addr = '0; u_taken = 0; u_guess = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk_cnt("R1 counters after reset");
    for (int i = 0; i < 16; i++) begin
      ask(2'b10, 32'(i * 4), 1'b1, "R1 vote slot after reset");
      ask(2'b11, 32'(i * 4), 1'b1, "R1 confidence slot after reset");
    end

    // R8: train slot 3 with the fixed strategy selected
    for (int k = 0; k < 3; k++) train(2'b00, 32'h0000_000C, 1'b1);
    // R2: fixed ignores the history and the tag
    ask(2'b00, 32'h0000_000C, 1'b1, "R2 fixed with taken history");
    ask(2'b00, 32'h0000_000C, 1'b0, "R2 fixed plain tag");
    ask(2'b10, 32'h0000_000C, 1'b0, "R8 vote trained under fixed");
    ask(2'b11, 32'h0000_000C, 1'b0, "R8 confidence trained under fixed");

    // R3: kind-based
    ask(2'b01, 32'h0000_0010, 1'b1, "R3 loop tag taken");
    ask(2'b01, 32'h0000_0010, 1'b0, "R3 ordinary tag not taken");
    ask(2'b01, 32'h0000_000C, 1'b0, "R3 ordinary ignores history");

    // R4: vote on slot 7
    train(2'b10, 32'h0000_001C, 1'b1);
    ask(2'b10, 32'h0000_001C, 1'b0, "R4 one of three taken");
    train(2'b10, 32'h0000_001C, 1'b1);
    ask(2'b10, 32'h0000_001C, 1'b0, "R4 two of three taken");
    train(2'b10, 32'h0000_001C, 1'b0);
    ask(2'b10, 32'h0000_001C, 1'b0, "R4 history 110 still taken");
    train(2'b10, 32'h0000_001C, 1'b0);
    ask(2'b10, 32'h0000_001C, 1'b0, "R4 history 100 not taken");
    train(2'b10, 32'h0000_001C, 1'b1);
    train(2'b10, 32'h0000_001C, 1'b0);
    ask(2'b10, 32'h0000_001C, 1'b0, "R4 alternating 010 not taken");

    // R5: confidence on slot 9
    train(2'b11, 32'h0000_0024, 1'b1);
    ask(2'b11, 32'h0000_0024, 1'b0, "R5 01 to 10 taken");
    for (int k = 0; k < 4; k++) train(2'b11, 32'h0000_0024, 1'b1);
    train(2'b11, 32'h0000_0024, 1'b0);
    ask(2'b11, 32'h0000_0024, 1'b0, "R5 saturated 11 survives one miss");
    train(2'b11, 32'h0000_0024, 1'b0);
    ask(2'b11, 32'h0000_0024, 1'b0, "R5 second miss flips");
    for (int k = 0; k < 4; k++) train(2'b11, 32'h0000_0024, 1'b0);
    train(2'b11, 32'h0000_0024, 1'b1);
    ask(2'b11, 32'h0000_0024, 1'b0, "R5 saturated 00 survives one taken");

    // R6: aliasing through ignored address bits
    for (int k = 0; k < 2; k++) train(2'b10, 32'h0000_0004, 1'b1);
    ask(2'b10, 32'hABCD_0047, 1'b0, "R6 alias shares slot 1");
    ask(2'b10, 32'h0000_0008, 1'b0, "R6 neighbour slot untouched");

    // R7: same-slot query and update, slot 5 holds 001
    train(2'b10, 32'h0000_0014, 1'b1);
    step(2'b10, 1'b1, 32'h0000_0014, 1'b0, 1'b1, 32'h0000_0014, 1'b1, 1'b0,
         "R7 query sees pre-update history");
    ask(2'b10, 32'h0000_0014, 1'b0, "R7 update landed afterwards");

    // R10: no query
    step(2'b01, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, "R10 no query loop tag");
    step(2'b11, 1'b0, 32'h0000_000C, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, "R10 no query trained slot");

    chk_cnt("R9 counters after directed");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] qa, ua;
      logic ut;
      qa = $urandom;
      ua = ($urandom_range(0, 3) == 0) ? qa : $urandom;
      ut = $urandom_range(0, 1);
      step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), qa,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ua, ut,
           1'($urandom_range(0, 1)), "R4/R5/R7 random");
      if (n % 500 == 499) chk_cnt("R9 counters random");
    end
    chk_cnt("R9 counters final");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule